// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital sequencing logic that sits beside a successive-approximation analog converter. It derives a conversion clock from the bus clock with a programmable prescaler. Each conversion is a sample phase followed by a conversion phase. The sample phase length comes from a coded table of conversion-clock counts, and the conversion phase is a fixed count. The block steps a fixed-length sequence of conversions across the analog channels. At the end of each conversion it captures the result word returned by the analog core.

Software drives the block through a two-register write port. The timing register sets the prescaler and the sample-length code. The control register sets the start channel, channel stepping, continuous scanning and external-trigger mode. A control write always discards any sequence in progress and starts again. In trigger mode, that same write arms the block, and each later rising edge on the trigger input starts one sequence. Toward the analog core the block drives a sample strobe, a convert strobe and the channel index.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the timing register reads zero, the strobes, the result-valid pulse and the sequence-complete flag are low, and the block stays idle until a control write.
- R2: One conversion-clock period is 2×(P+1) bus cycles, where P is the prescaler field. A conversion lasts (S+12) conversion-clock periods: S periods of sampling, then 12 of converting.
- R3: The sample-length code C in timing bits 7:5 gives S = 4, 6, 8, 10, 12 for C = 0 to 4, and S = 16, 20, 24 for C = 5 to 7.
- R4: In non-trigger mode, a control write starts a sequence at once. In the first cycle after the write edge, sample_o is high and chan_o equals the start channel from control bits 3:0. sample_o and convert_o are never high together.
- R5: A control write during a running sequence aborts it with no result. The new sequence's timing is measured from that write, with the prescaler restarted.
- R6: With control bit 4 set, the channel advances by one modulo 16 after every conversion. With it clear, every conversion uses the start channel. The channel stays fixed throughout a sample phase.
- R7: A sequence is four conversions. After the fourth result, seq_done_o is set. It stays set until the next control write, which clears it.
- R8: With control bit 5 set, a new sequence begins at the start channel right after each completed one, with no idle cycle.
- R9: With control bit 6 set, a control write arms the block but starts nothing. Each rising edge of ext_trig_i while armed starts one sequence. Edges while a sequence runs, or before any arming write, are ignored. After the sequence the block is armed again.
- R10: At the end of each conversion phase, result_i is captured into result_o, and result_valid_o pulses high for one cycle.
- R11: A timing-register write (wr_addr_i = 0) sets the prescaler in bits 4:0 and the code in bits 7:5. timing_o reads it back in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects the timing register, 1 selects the control register |
| wr_data_i | input | 8 | Write data |
| ext_trig_i | input | 1 | External trigger, rising edge active |
| result_i | input | RES_W | Result word from the analog core |
| timing_o | output | 8 | Timing register readback |
| sample_o | output | 1 | Sample phase strobe |
| convert_o | output | 1 | Conversion phase strobe |
| chan_o | output | 4 | Channel index for the current conversion |
| result_o | output | RES_W | Last captured result |
| result_valid_o | output | 1 | One-cycle pulse when result_o updates |
| seq_done_o | output | 1 | Sequence-complete flag |

## Verification
The bench runs every sample-length code. For each conversion it checks the sample-phase width and the exact result cycle. A wrong entry in the code table, or an off-by-one in the prescaler, shows up as a shifted result cycle. An abort is issued in the middle of a conversion phase at an odd offset from the prescaler period. A design that fails to clear its prescaler, or that leaks the aborted result, delivers results on the wrong cycles or delivers an unexpected one. The channel is stepped across the 15-to-0 wrap, which exposes a wrong modulus. The bench also sends triggers before arming and while a sequence runs. A design that honours either one starts an extra sequence or moves the due cycles. The done flag is sampled under scan mode: it must rise exactly when the fourth result lands, while sampling has already restarted.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CHAN_W = 4;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned SLEN_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SAMPLE,
    ST_CONVERT
  } seq_state_e;

  // control word layout, msb first: trigger mode, scan, step, start channel
  typedef struct packed {
    logic              trig_mode;
    logic              scan;
    logic              step;
    logic [CHAN_W-1:0] chan;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // coded sample length: linear steps of 2 up to 12, then steps of 4
  function automatic logic [SLEN_W-1:0] sample_len(input logic [CODE_W-1:0] code);
    logic [SLEN_W-1:0] c;
    c = SLEN_W'(code);
    if (code < CODE_W'(5)) return SLEN_W'(4) + (c << 1);
    return SLEN_W'(16) + ((c - SLEN_W'(5)) << 2);
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int unsigned PRS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [PRS_W-1:0] prs_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = PRS_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // period 2*(prs+1) bus cycles, last count is 2*prs+1
  assign limit  = {prs_i, 1'b1};
  assign tick_o = run_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i || !run_i)         cnt_q <= '0;
    else if (cnt_q >= limit)            cnt_q <= '0;
    else                                cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic event_o
);
  logic trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  assign event_o = trig_i && !trig_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W    = 12,
  parameter int unsigned CONV_CYC = 12,
  parameter int unsigned SEQ_LEN  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  ctrl_t             ctrl_i,
  input  logic              tick_i,
  input  logic              trig_evt_i,
  input  logic [SLEN_W-1:0] slen_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              start_o,
  output logic              run_o,
  output logic              sample_o,
  output logic              convert_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [RES_W-1:0]  result_o,
  output logic              result_valid_o,
  output logic              seq_done_o
);
  localparam int unsigned PH_MAX = (CONV_CYC > 24) ? CONV_CYC : 24;
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
  localparam int unsigned IDX_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [PH_W-1:0]  CONV_LAST = PH_W'(CONV_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(SEQ_LEN - 1);

  seq_state_e        state_q;
  ctrl_t             ctrl_q;
  logic [PH_W-1:0]   ph_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CHAN_W-1:0] chan_q;
  logic [RES_W-1:0]  res_q;
  logic              valid_q;
  logic              done_q;
  logic              trig_start;
  logic [PH_W-1:0]   samp_last;

  assign samp_last  = PH_W'(slen_i) - PH_W'(1);
  assign trig_start = (state_q == ST_ARMED) && trig_evt_i;
  assign start_o    = ctrl_wr_i || trig_start;
  assign sample_o   = (state_q == ST_SAMPLE);
  assign convert_o  = (state_q == ST_CONVERT);
  assign run_o      = sample_o || convert_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
      ph_q    <= '0;
      idx_q   <= '0;
      chan_q  <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (ctrl_wr_i) begin
      // abort and restart
      ctrl_q  <= ctrl_i;
      ph_q    <= '0;
      idx_q   <= '0;
      chan_q  <= ctrl_i.chan;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      state_q <= ctrl_i.trig_mode ? ST_ARMED : ST_SAMPLE;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: ;
        ST_ARMED: begin
          if (trig_evt_i) begin
            state_q <= ST_SAMPLE;
            ph_q    <= '0;
            idx_q   <= '0;
            chan_q  <= ctrl_q.chan;
          end
        end
        ST_SAMPLE: begin
          if (tick_i) begin
            if (ph_q >= samp_last) begin
              state_q <= ST_CONVERT;
              ph_q    <= '0;
            end else begin
              ph_q <= ph_q + PH_W'(1);
            end
          end
        end
        ST_CONVERT: begin
          if (tick_i) begin
            if (ph_q >= CONV_LAST) begin
              ph_q    <= '0;
              res_q   <= result_i;
              valid_q <= 1'b1;
              if (idx_q == IDX_LAST) begin
                done_q <= 1'b1;
                idx_q  <= '0;
                chan_q <= ctrl_q.chan;
                if (ctrl_q.scan)           state_q <= ST_SAMPLE;
                else if (ctrl_q.trig_mode) state_q <= ST_ARMED;
                else                       state_q <= ST_IDLE;
              end else begin
                idx_q   <= idx_q + IDX_W'(1);
                chan_q  <= ctrl_q.step ? chan_q + CHAN_W'(1) : chan_q;
                state_q <= ST_SAMPLE;
              end
            end else begin
              ph_q <= ph_q + PH_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign chan_o         = chan_q;
  assign result_o       = res_q;
  assign result_valid_o = valid_q;
  assign seq_done_o     = done_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned PRS_W    = 5,
  parameter int unsigned RES_W    = 12,
  parameter int unsigned CONV_CYC = 12,
  parameter int unsigned SEQ_LEN  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    wr_addr_i,
  input  logic [CODE_W+PRS_W-1:0] wr_data_i,
  input  logic                    ext_trig_i,
  input  logic [RES_W-1:0]        result_i,
  output logic [CODE_W+PRS_W-1:0] timing_o,
  output logic                    sample_o,
  output logic                    convert_o,
  output logic [CHAN_W-1:0]       chan_o,
  output logic [RES_W-1:0]        result_o,
  output logic                    result_valid_o,
  output logic                    seq_done_o
);
  localparam int unsigned REG_W = CODE_W + PRS_W;

  logic [REG_W-1:0]  timing_q;
  logic              ctrl_wr;
  ctrl_t             ctrl_word;
  logic              tick;
  logic              trig_evt;
  logic              start;
  logic              run;
  logic [SLEN_W-1:0] slen;
  logic              unused_wr_bits;

  assign ctrl_wr        = wr_en_i && wr_addr_i;
  assign ctrl_word      = ctrl_t'(wr_data_i[CTRL_W-1:0]);
  assign unused_wr_bits = ^wr_data_i[REG_W-1:CTRL_W];
  assign slen           = sample_len(timing_q[REG_W-1:PRS_W]);
  assign timing_o       = timing_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     timing_q <= '0;
    else if (wr_en_i && !wr_addr_i)  timing_q <= wr_data_i;
  end

  adc_clk_div #(.PRS_W(PRS_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start),
    .run_i   (run),
    .prs_i   (timing_q[PRS_W-1:0]),
    .tick_o  (tick)
  );

  adc_trig_edge u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (ext_trig_i),
    .event_o (trig_evt)
  );

  adc_seq_fsm #(
    .RES_W    (RES_W),
    .CONV_CYC (CONV_CYC),
    .SEQ_LEN  (SEQ_LEN)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctrl_wr_i      (ctrl_wr),
    .ctrl_i         (ctrl_word),
    .tick_i         (tick),
    .trig_evt_i     (trig_evt),
    .slen_i         (slen),
    .result_i       (result_i),
    .start_o        (start),
    .run_o          (run),
    .sample_o       (sample_o),
    .convert_o      (convert_o),
    .chan_o         (chan_o),
    .result_o       (result_o),
    .result_valid_o (result_valid_o),
    .seq_done_o     (seq_done_o)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned CHAN_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_addr_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic [REG_W-1:0]  timing_o,
  input logic              sample_o,
  input logic              convert_o,
  input logic [CHAN_W-1:0] chan_o,
  input logic              result_valid_o,
  input logic              seq_done_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && wr_addr_i;

  assert_phase_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && convert_o));

  assert_start_now_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wr_data_i[6]) |=> (sample_o && chan_o == $past(wr_data_i[CHAN_W-1:0])));

  assert_armed_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wr_data_i[6]) |=> (!sample_o && !convert_o));

  assert_done_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> !seq_done_o);

  assert_valid_after_conv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> $past(convert_o));

  assert_chan_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && $past(sample_o) && !$past(ctrl_wr)) |-> $stable(chan_o));

  assert_timing_wr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_addr_i) |=> (timing_o == $past(wr_data_i)));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.REG_W(REG_W), .CHAN_W(adc_seq_pkg::CHAN_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_addr_i      (wr_addr_i),
  .wr_data_i      (wr_data_i),
  .timing_o       (timing_o),
  .sample_o       (sample_o),
  .convert_o      (convert_o),
  .chan_o         (chan_o),
  .result_valid_o (result_valid_o),
  .seq_done_o     (seq_done_o)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  typedef struct {
    int chan;
    int due;
    int slen;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        trig = 1'b0;
  logic [11:0] res_in;
  logic [7:0]  timing;
  logic        sample, convert, rvalid, done;
  logic [3:0]  chan;
  logic [11:0] res_out;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    cur_prs = 0;
  int    cur_smp = 0;
  item_t q[$];
  int    samp_run = 0;
  int    samp_last = 0;
  bit    prev_samp = 1'b0;
  int    conv_chan = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // analog core model: result word derived from the channel
  assign res_in = {4'h9, chan, ~chan};

  adc_seq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ext_trig_i(trig), .result_i(res_in),
    .timing_o(timing), .sample_o(sample), .convert_o(convert), .chan_o(chan),
    .result_o(res_out), .result_valid_o(rvalid), .seq_done_o(done)
  );

  function automatic int slen_of(int code);
    int tbl[8] = '{4, 6, 8, 10, 12, 16, 20, 24};
    return tbl[code];
  endfunction

  function automatic int period(int prs, int smp);
    return (slen_of(smp) + 12) * 2 * (prs + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @cyc %0d", req, act, exp, cyc);
    end
  endtask

  task automatic push_items(int start, bit step, int n, int w);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.chan = step ? (start + (k % 4)) % 16 : start;
      it.due  = w + (k + 1) * period(cur_prs, cur_smp);
      it.slen = slen_of(cur_smp) * 2 * (cur_prs + 1);
      q.push_back(it);
    end
  endtask

  task automatic wr_timing(int prs, int smp);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = {3'(smp), 5'(prs)};
    @(negedge clk);
    wr_en = 1'b0;
    cur_prs = prs; cur_smp = smp;
    chk(timing == {3'(smp), 5'(prs)}, "R11 timing readback", int'(timing), int'({3'(smp), 5'(prs)}));
  endtask

  task automatic wr_ctrl(bit tmode, bit scan, bit step, int start, int n);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = {1'b0, tmode, scan, step, 4'(start)};
    @(negedge clk);
    wr_en = 1'b0;
    q.delete();
    if (!tmode) push_items(start, step, n, cyc);
  endtask

  task automatic pulse_trig(bit expect_start, int start, bit step, int n);
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    if (expect_start) push_items(start, step, n, cyc);
  endtask

  task automatic wait_empty();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: sample width and result scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (sample) samp_run = prev_samp ? samp_run + 1 : 1;
      if (prev_samp && !sample) samp_last = samp_run;
      prev_samp = sample;
      if (convert) conv_chan = int'(chan);
      if (rvalid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R5/R9 unexpected result", conv_chan, -1);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(cyc == it.due, "R2 result cycle", cyc, it.due);
          chk(conv_chan == it.chan, "R6 channel", conv_chan, it.chan);
          chk(samp_last == it.slen, "R3 sample width", samp_last, it.slen);
          chk(res_out == {4'h9, 4'(it.chan), ~4'(it.chan)}, "R10 result word",
              int'(res_out), int'({4'h9, 4'(it.chan), ~4'(it.chan)}));
        end
      end
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(timing == 8'h00, "R1 timing reset", int'(timing), 0);
    chk(!sample && !convert && !rvalid && !done, "R1 outputs idle",
        int'({sample, convert, rvalid, done}), 0);

    // R9 trigger before any arming write is ignored
    pulse_trig(1'b0, 0, 1'b0, 0);
    repeat (20) @(negedge clk);
    chk(!sample && !convert, "R9 unarmed trigger", int'({sample, convert}), 0);

    // R2/R4 basic single-channel sequence
    wr_timing(0, 0);
    wr_ctrl(1'b0, 1'b0, 1'b0, 3, 4);
    chk(sample == 1'b1, "R4 sample starts", int'(sample), 1);
    chk(chan == 4'd3, "R4 start channel", int'(chan), 3);
    wait_empty();
    chk(done == 1'b1, "R7 done set", int'(done), 1);
    chk(!sample && !convert, "R7 idle after sequence", int'({sample, convert}), 0);

    // R6 wrap across 15->0, R7 done cleared by write
    wr_timing(2, 5);
    wr_ctrl(1'b0, 1'b0, 1'b1, 14, 4);
    chk(done == 1'b0, "R7 done cleared", int'(done), 0);
    wait_empty();

    // R3 every sample code
    for (int c = 0; c < 8; c++) begin
      wr_timing(0, c);
      wr_ctrl(1'b0, 1'b0, 1'b1, c * 2, 4);
      wait_empty();
    end

    // R5 abort inside a conversion phase at odd prescaler offset
    wr_timing(1, 0);
    wr_ctrl(1'b0, 1'b0, 1'b1, 5, 4);
    repeat (85) @(negedge clk);
    chk(convert == 1'b1, "R5 abort point in convert", int'(convert), 1);
    wr_ctrl(1'b0, 1'b0, 1'b0, 9, 4);
    chk(sample == 1'b1 && chan == 4'd9, "R5 restart", int'(chan), 9);
    wait_empty();

    // R8 scan restarts, done rises with fourth result
    wr_timing(0, 0);
    wr_ctrl(1'b0, 1'b1, 1'b1, 2, 8);
    w = cyc;
    while (cyc < w + 4 * period(0, 0) + 2) @(negedge clk);
    chk(done == 1'b1, "R7 done under scan", int'(done), 1);
    chk(sample == 1'b1, "R8 scan restart", int'(sample), 1);
    chk(chan == 4'd2, "R8 restart channel", int'(chan), 2);

    // R9 trigger mode
    wr_ctrl(1'b1, 1'b0, 1'b1, 7, 0);
    repeat (30) @(negedge clk);
    chk(!sample && !convert, "R9 armed quiet", int'({sample, convert}), 0);
    pulse_trig(1'b1, 7, 1'b1, 4);
    repeat (50) @(negedge clk);
    pulse_trig(1'b0, 0, 1'b0, 0);
    wait_empty();
    repeat (10) @(negedge clk);
    chk(!sample && !convert, "R9 rearmed idle", int'({sample, convert}), 0);
    pulse_trig(1'b1, 7, 1'b1, 4);
    wait_empty();
    chk(q.size() == 0, "R9 all results seen", q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule